// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction's operand lives for a small 8-bit CPU. The decoder hands it an addressing-mode code, the current index register and the address of the opcode. The block then pulls in the instruction bytes that follow the opcode, one per clock, over a valid/ready handshake. Once it has every byte the mode needs, it pulses `done` and presents three results: the 16-bit operand address, the total instruction length, and, for the bit-test-and-branch form, the branch destination.

Five modes are supported. Three of them keep the operand inside page zero by forcing the high address byte to zero: the one-byte direct mode, indexed with no offset, and the operand of the bit-branch form. The extended mode carries a full 16-bit address. The indexed mode with an 8-bit offset adds two unsigned bytes, so its range is nine bits wide. A mode code outside this set is rejected with a one-cycle error pulse. Decoding, data movement and memory access happen elsewhere.

Top module: `eag_top`

## Requirements
- R1: Direct mode (code 0) takes one byte after the opcode. The result address is {8'h00, byte} and the length is 2.
- R2: Extended mode (code 1) takes two bytes after the opcode, high byte first. The result address is {high, low} and the length is 3.
- R3: Indexed mode with no offset (code 2) takes no bytes. The result address is {8'h00, index} and the length is 1. `byte_ready` is never raised for this mode.
- R4: Indexed mode with an 8-bit offset (code 3) takes one byte. The result address is the unsigned sum index + offset, which lies in 16'h0000..16'h01FE, and the length is 2.
- R5: Bit-branch mode (code 4) takes two bytes: first an operand address, then a signed displacement. The result address is {8'h00, first}, the length is 3, `has_branch` is 1, and `branch_target` = opcode address + 3 + sign-extended displacement. `has_branch` is 0 for every other mode.
- R6: The branch target is computed modulo 2^16, in both the forward and the backward direction.
- R7: `done` is high for exactly one cycle. It rises in the cycle after the edge that accepts the last required byte, or after the accepting edge when the mode needs no bytes. It stays low before that.
- R8: A mode code of 5, 6 or 7 gives a one-cycle `error` with no `done`. After it, `start_ready` is high again.
- R9: A synchronous active-high `rst` abandons a partly collected instruction and returns the block to idle: `start_ready` high, `done` low.
- R10: The index value is sampled on the edge that accepts the mode. Later changes on `index_reg` do not alter the result.
- R11: A byte is consumed only on an edge where both `byte_valid` and `byte_ready` are high. Cycles with `byte_valid` low leave the collection where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Mode request valid |
| start_ready | output | 1 | Block is idle and accepts a request |
| mode_code | input | 3 | Addressing mode (0 direct, 1 extended, 2 indexed, 3 indexed+offset, 4 bit-branch) |
| index_reg | input | 8 | Index register value |
| opc_addr | input | 16 | Address of the opcode byte |
| byte_valid | input | 1 | Instruction byte valid |
| byte_ready | output | 1 | Block is collecting bytes |
| byte_data | input | 8 | Instruction byte after the opcode |
| done | output | 1 | One-cycle pulse: results are valid |
| error | output | 1 | One-cycle pulse: unsupported mode |
| eff_addr | output | 16 | Operand address |
| branch_target | output | 16 | Branch destination (bit-branch only) |
| has_branch | output | 1 | branch_target is meaningful |
| instr_len | output | 2 | Instruction length in bytes, opcode included |

## Verification
Every mode is run with chosen bytes, so that each result shows which byte fed which half of the address. Extended mode uses unequal high and low bytes, which exposes a swapped order. Indexed with offset is run at FF+FF, which exposes a sum cut to eight bits. The bit-branch form is given a positive displacement that wraps past FFFF and a negative displacement of 0x80, which separates sign extension from zero extension and checks that the next-instruction base is opcode+3. Other runs insert stall cycles, change the index after acceptance, present an illegal code, and reset part-way through collection, to tell a correct handshake and capture point apart from a loose one.

// File: rtl/eag_pkg.sv
package eag_pkg;

    parameter int ADDR_W  = 16;
    parameter int BYTE_W  = 8;
    parameter int MAX_OPB = 2;
    parameter int LEN_W   = 2;
    parameter int CNT_W   = 2;

    typedef enum logic [2:0] {
        AM_DIRECT = 3'd0,
        AM_EXTEND = 3'd1,
        AM_INDEX  = 3'd2,
        AM_IDXOFF = 3'd3,
        AM_BITBR  = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DONE,
        ST_ERR
    } state_e;

    typedef struct packed {
        logic [2:0]                   mode;
        logic [BYTE_W-1:0]            index;
        logic [ADDR_W-1:0]            base;
        logic [MAX_OPB*BYTE_W-1:0]    opb;
    } capture_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] target;
        logic              branch;
        logic [LEN_W-1:0]  len;
    } result_t;

    function automatic logic mode_ok(input logic [2:0] m);
        return m <= 3'(AM_BITBR);
    endfunction

    function automatic logic [CNT_W-1:0] opnd_bytes(input logic [2:0] m);
        case (m)
            3'(AM_DIRECT), 3'(AM_IDXOFF): return CNT_W'(1);
            3'(AM_EXTEND), 3'(AM_BITBR):  return CNT_W'(2);
            default:                      return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
    import eag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       mode_code,
    input  logic             byte_valid,
    output logic             start_ready,
    output logic             byte_ready,
    output logic             accept,
    output logic             take_byte,
    output logic [CNT_W-1:0] slot,
    output logic             done,
    output logic             error
);
    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] need_q, need_d;

    assign start_ready = (state_q == ST_IDLE);
    assign byte_ready  = (state_q == ST_FETCH);
    assign accept      = start && start_ready;
    assign take_byte   = byte_valid && byte_ready;
    assign slot        = cnt_q;
    assign done        = (state_q == ST_DONE);
    assign error       = (state_q == ST_ERR);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        need_d  = need_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    cnt_d  = '0;
                    need_d = opnd_bytes(mode_code);
                    if (!mode_ok(mode_code))
                        state_d = ST_ERR;
                    else if (opnd_bytes(mode_code) == '0)
                        state_d = ST_DONE;
                    else
                        state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (take_byte) begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q + CNT_W'(1) == need_q)
                        state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            need_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            need_q  <= need_d;
        end
    end
endmodule

// File: rtl/eag_collect.sv
module eag_collect
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [2:0]        mode_code,
    input  logic [BYTE_W-1:0] index_reg,
    input  logic [ADDR_W-1:0] opc_addr,
    input  logic              take_byte,
    input  logic [CNT_W-1:0]  slot,
    input  logic [BYTE_W-1:0] byte_data,
    output capture_t          cap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap.mode  <= '0;
            cap.index <= '0;
            cap.base  <= '0;
        end else if (accept) begin
            cap.mode  <= mode_code;
            cap.index <= index_reg;
            cap.base  <= opc_addr;
        end
    end

    for (genvar g = 0; g < MAX_OPB; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || accept)
                cap.opb[g*BYTE_W +: BYTE_W] <= '0;
            else if (take_byte && slot == CNT_W'(g))
                cap.opb[g*BYTE_W +: BYTE_W] <= byte_data;
        end
    end
endmodule

// File: rtl/eag_compute.sv
module eag_compute
    import eag_pkg::*;
(
    input  capture_t cap,
    output result_t  res
);
    logic [BYTE_W-1:0] b0, b1;
    logic [ADDR_W-1:0] next_pc;

    assign b0 = cap.opb[0 +: BYTE_W];
    assign b1 = cap.opb[BYTE_W +: BYTE_W];

    always_comb begin
        res.len    = LEN_W'(opnd_bytes(cap.mode)) + LEN_W'(1);
        res.branch = (cap.mode == 3'(AM_BITBR));
        next_pc    = cap.base + ADDR_W'(res.len);
        res.target = '0;
        case (cap.mode)
            3'(AM_EXTEND): res.addr = {b0, b1};
            3'(AM_INDEX):  res.addr = ADDR_W'(cap.index);
            3'(AM_IDXOFF): res.addr = ADDR_W'(cap.index) + ADDR_W'(b0);
            3'(AM_BITBR): begin
                res.addr   = ADDR_W'(b0);
                res.target = next_pc + {{(ADDR_W-BYTE_W){b1[BYTE_W-1]}}, b1};
            end
            default:       res.addr = ADDR_W'(b0);
        endcase
    end
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              start_ready,
    input  logic [2:0]        mode_code,
    input  logic [BYTE_W-1:0] index_reg,
    input  logic [ADDR_W-1:0] opc_addr,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] branch_target,
    output logic              has_branch,
    output logic [LEN_W-1:0]  instr_len
);
    logic             accept, take_byte;
    logic [CNT_W-1:0] slot;
    capture_t         cap;
    result_t          res;

    eag_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode_code(mode_code),
        .byte_valid(byte_valid), .start_ready(start_ready),
        .byte_ready(byte_ready), .accept(accept), .take_byte(take_byte),
        .slot(slot), .done(done), .error(error)
    );

    eag_collect u_coll (
        .clk(clk), .rst(rst), .accept(accept), .mode_code(mode_code),
        .index_reg(index_reg), .opc_addr(opc_addr), .take_byte(take_byte),
        .slot(slot), .byte_data(byte_data), .cap(cap)
    );

    eag_compute u_comp (.cap(cap), .res(res));

    assign eff_addr      = res.addr;
    assign branch_target = res.target;
    assign has_branch    = res.branch;
    assign instr_len     = res.len;
endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              start_ready,
    input logic [2:0]        mode_code,
    input logic [BYTE_W-1:0] index_reg,
    input logic              byte_ready,
    input logic              done,
    input logic              error,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              has_branch,
    input logic [LEN_W-1:0]  instr_len
);
    logic [2:0]        m_seen;
    logic [BYTE_W-1:0] x_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_seen <= '0;
            x_seen <= '0;
        end else if (start && start_ready) begin
            m_seen <= mode_code;
            x_seen <= index_reg;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        error |=> (!error && start_ready));

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R11
    hs_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_ready && byte_ready));

    // R3
    idx_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (done && m_seen == 3'(AM_INDEX)) |-> (eff_addr == ADDR_W'(x_seen) && instr_len == LEN_W'(1)));

    // R1
    direct_page_chk: assert property (@(posedge clk) disable iff (rst)
        (done && m_seen == 3'(AM_DIRECT)) |-> (eff_addr[ADDR_W-1:BYTE_W] == '0));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done && m_seen == 3'(AM_IDXOFF)) |-> (eff_addr <= ADDR_W'(16'h01FE)));

    // R5
    branch_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (has_branch == (m_seen == 3'(AM_BITBR))));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (start_ready && !done && !error));
endmodule

bind eag_top eag_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .start_ready(start_ready),
    .mode_code(mode_code), .index_reg(index_reg), .byte_ready(byte_ready),
    .done(done), .error(error), .eff_addr(eff_addr),
    .has_branch(has_branch), .instr_len(instr_len)
);

// File: tb/eag_top_bench.sv
module eag_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        start_ready;
    logic [2:0]  mode_code = '0;
    logic [7:0]  index_reg = '0;
    logic [15:0] opc_addr = '0;
    logic        byte_valid = 1'b0;
    logic        byte_ready;
    logic [7:0]  byte_data = '0;
    logic        done, error;
    logic [15:0] eff_addr, branch_target;
    logic        has_branch;
    logic [1:0]  instr_len;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    eag_top u_eag_top (
        .clk(clk), .rst(rst), .start(start), .start_ready(start_ready),
        .mode_code(mode_code), .index_reg(index_reg), .opc_addr(opc_addr),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .done(done), .error(error), .eff_addr(eff_addr),
        .branch_target(branch_target), .has_branch(has_branch),
        .instr_len(instr_len)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, fails);
            $finish;
        end
    endtask

    // Issue a request; returns at the negedge after the accepting edge.
    task automatic issue(input logic [2:0] m, input logic [7:0] x, input logic [15:0] pc);
        @(negedge clk);
        start = 1'b1; mode_code = m; index_reg = x; opc_addr = pc;
        while (!start_ready) @(negedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Present one byte after 'gap' idle cycles; returns at the negedge after acceptance.
    task automatic feed(input logic [7:0] b, input int gap, input string req);
        bit took;
        for (int i = 0; i < gap; i++) begin
            chk(!done, req, done, 0);
            @(negedge clk);
        end
        byte_valid = 1'b1; byte_data = b;
        do begin
            took = byte_ready;
            @(negedge clk);
        end while (!took);
        byte_valid = 1'b0;
    endtask

    task automatic expect_done(input string req, input logic [15:0] ea,
                               input logic [1:0] len, input bit br, input logic [15:0] tgt);
        chk(done === 1'b1, req, done, 1);
        chk(eff_addr === ea, req, eff_addr, ea);
        chk(instr_len === len, req, instr_len, len);
        chk(has_branch === br, req, has_branch, br);
        if (br) chk(branch_target === tgt, req, branch_target, tgt);
        @(negedge clk);
        chk(done === 1'b0, "R7", done, 0);
    endtask

    task automatic t_reset();
        chk(start_ready === 1'b1 && done === 1'b0 && error === 1'b0, "R9", {start_ready, done, error}, 3'b100);
    endtask

    task automatic t_direct();
        issue(3'd0, 8'h77, 16'h2000);
        feed(8'h5A, 0, "R1");
        expect_done("R1", 16'h005A, 2'd2, 1'b0, 16'h0);
    endtask

    task automatic t_extended();
        issue(3'd1, 8'h00, 16'h3000);
        feed(8'hC3, 0, "R2");
        chk(done === 1'b0, "R7", done, 0);
        feed(8'h1E, 2, "R11");
        expect_done("R2", 16'hC31E, 2'd3, 1'b0, 16'h0);
    endtask

    task automatic t_index();
        @(negedge clk);
        start = 1'b1; mode_code = 3'd2; index_reg = 8'hA4; byte_valid = 1'b1; byte_data = 8'h11;
        @(negedge clk);
        start = 1'b0; index_reg = 8'h00;
        chk(byte_ready === 1'b0, "R3", byte_ready, 0);
        expect_done("R3", 16'h00A4, 2'd1, 1'b0, 16'h0);
        byte_valid = 1'b0;
    endtask

    task automatic t_idxoff();
        issue(3'd3, 8'hFF, 16'h0100);
        feed(8'hFF, 0, "R4");
        expect_done("R4", 16'h01FE, 2'd2, 1'b0, 16'h0);
        issue(3'd3, 8'h10, 16'h0100);
        index_reg = 8'hE0;
        feed(8'h22, 1, "R10");
        expect_done("R10", 16'h0032, 2'd2, 1'b0, 16'h0);
    endtask

    task automatic t_bitbr();
        logic [15:0] t;
        t = 16'h1000 + 16'd3 - 16'd128;
        issue(3'd4, 8'h00, 16'h1000);
        feed(8'h3C, 0, "R5");
        feed(8'h80, 0, "R5");
        expect_done("R5", 16'h003C, 2'd3, 1'b1, t);
        t = 16'hFFFE + 16'd3 + 16'd5;
        issue(3'd4, 8'h00, 16'hFFFE);
        feed(8'h01, 1, "R6");
        feed(8'h05, 0, "R6");
        expect_done("R6", 16'h0001, 2'd3, 1'b1, t);
    endtask

    task automatic t_bad_mode();
        issue(3'd6, 8'h00, 16'h0);
        chk(error === 1'b1 && done === 1'b0, "R8", {error, done}, 2'b10);
        @(negedge clk);
        chk(error === 1'b0 && start_ready === 1'b1, "R8", {error, start_ready}, 2'b01);
    endtask

    task automatic t_mid_reset();
        issue(3'd1, 8'h00, 16'h0);
        feed(8'hAB, 0, "R9");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(start_ready === 1'b1 && byte_ready === 1'b0, "R9", {start_ready, byte_ready}, 2'b10);
        issue(3'd1, 8'h00, 16'h0);
        feed(8'h12, 0, "R9");
        feed(8'h34, 0, "R9");
        expect_done("R9", 16'h1234, 2'd3, 1'b0, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direct();
        t_extended();
        t_index();
        t_idxoff();
        t_bitbr();
        t_bad_mode();
        t_mid_reset();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule